// File: doc/BRIEF.md
# Serial Port Controller with Receive and Transmit FIFOs

This block is an asynchronous serial transmitter and receiver that a CPU operates through a small memory-mapped register port. Characters use the 8N1 format: one low start bit, eight data bits sent least significant bit first, and one high stop bit. The system clock is the 48 MHz reference. A programmable divisor sets the length of one bit to divisor + 1 clock cycles, so the bit rate is 48 MHz / (divisor + 1). The reset divisor of 23 gives 2.0 MHz. The range meant for use is 23 to 4999 inclusive.

Bytes written to the data register enter a transmit FIFO. The transmitter takes them out of that FIFO on its own and sends them. Between characters it holds the line high. Received bytes collect in an eight-entry receive FIFO, and a read of the data register removes the oldest one. A status register reports transmit readiness, receive occupancy, a full-packet condition and overflow. A control bit in that register chooses what drives the receive interrupt: either "any byte waiting" or "eight bytes buffered". The overflow flag is cleared by writing 1 to it.

The register port is synchronous. A read returns its data on `rd_data` one clock after `rd_en` is sampled. The addresses are 0 for data, 1 for status/control and 2 for the divisor. Address 3 reads as zero.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset, status (address 1) reads 0x0010, the divisor register (address 2) reads 0x0017, `tx_o` is high and `rx_irq` is low.
- R2: The divisor register is read/write in bits [12:0]. One serial bit on both the transmit and receive sides lasts divisor + 1 clock cycles.
- R3: The transmitter sends a low start bit, then the eight data bits least significant bit first, then a high stop bit. The line stays high when no character is being sent. Bytes waiting in the transmit FIFO are sent one after another in write order without further CPU action.
- R4: Status bit 4 reads 1 when the transmit FIFO (TX_DEPTH entries, 4 by default) can take another byte and 0 when it is full. A write to address 0 while the FIFO is full is dropped, and that byte is never sent.
- R5: The receiver checks the start bit at its midpoint and samples each data bit at its midpoint. If the line is high again at the middle of the start bit, the start is rejected and no byte is stored. A byte is stored only when its stop bit samples high.
- R6: Status bit 0 reads 1 while at least one byte is in the receive FIFO. A read of address 0 returns the oldest byte in bits [7:0], with the upper bits zero, and removes it from the FIFO. A read of address 0 with the FIFO empty returns 0.
- R7: Status bit 1 reads 1 exactly when the receive FIFO holds eight bytes.
- R8: Status bit 3 is a read/write mode bit. At 0, `rx_irq` equals status bit 0. At 1, `rx_irq` equals status bit 1.
- R9: A byte that arrives while the receive FIFO is full is discarded, the stored bytes are kept unchanged, and status bit 2 sets. Writing status with bit 2 at 1 clears the flag, and writing it with bit 2 at 0 leaves it unchanged.
- R10: Reserved bits read as 0 and ignore writes. These are status bits [15:5] and divisor bits [15:13]. Status bits 4, 1 and 0 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 data, 1 status/control, 2 divisor |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe; a read of address 0 removes a receive byte |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| rx_irq | output | 1 | Receive interrupt; its source is chosen by status bit 3 |

## Verification
The bench builds the block with its default parameters: a four-entry transmit FIFO, an eight-entry receive FIFO and a 13-bit divisor. The small transmit depth lets a five-byte burst fill the FIFO behind the byte already in the shifter, which brings the dropped-write case within reach. The reset divisor of 23 keeps a character at 240 cycles, so a nine-byte receive burst that overflows takes only about 2,200 cycles. Random divisors from 23 to 60 then vary the bit period and the midpoint sampling on both directions.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    localparam int REG_W = 16;
    localparam int BYTE_W = 8;
    localparam int FRAME_BITS = 10;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_BAUD = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic tx_ready;
        logic pkt_mode;
        logic overflow;
        logic pkt_ready;
        logic rx_ready;
    } status_t;

    function automatic logic [REG_W-1:0] pack_status(status_t s);
        return {{(REG_W - $bits(status_t)){1'b0}}, s};
    endfunction

endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
    parameter int W = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (do_pop)
                rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import serial_port_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              busy,
    output logic              tx_o
);
    localparam int BN_W = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [BN_W-1:0]       bit_n;
    logic [DIV_W-1:0]      cnt;

    assign fifo_pop = !busy && !fifo_empty;
    assign tx_o     = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            bit_n <= '0;
            cnt   <= '0;
        end else if (fifo_pop) begin
            busy  <= 1'b1;
            shreg <= {1'b1, fifo_data, 1'b0};
            bit_n <= '0;
            cnt   <= div;
        end else if (busy) begin
            if (cnt == '0) begin
                if (bit_n == BN_W'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                    bit_n <= bit_n + 1'b1;
                    cnt   <= div;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import serial_port_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              rx_i,
    output logic              push,
    output logic [BYTE_W-1:0] data
);
    rx_state_e        state;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bit_n;
    logic             rx_m, rx_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m  <= 1'b1;
            rx_s  <= 1'b1;
            state <= RX_IDLE;
            cnt   <= '0;
            bit_n <= '0;
            data  <= '0;
            push  <= 1'b0;
        end else begin
            rx_m <= rx_i;
            rx_s <= rx_m;
            push <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state <= RX_START;
                        cnt   <= div >> 1;
                    end
                end
                RX_START: begin
                    if (cnt == '0) begin
                        if (!rx_s) begin
                            state <= RX_DATA;
                            cnt   <= div;
                            bit_n <= '0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == '0) begin
                        data <= {rx_s, data[BYTE_W-1:1]};
                        cnt  <= div;
                        if (bit_n == 3'd7)
                            state <= RX_STOP;
                        else
                            bit_n <= bit_n + 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == '0) begin
                        push  <= rx_s;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
    import serial_port_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 8,
    parameter int DIV_W = 13,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(23),
    localparam int TXC_W = $clog2(TX_DEPTH + 1),
    localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic             rx_i,
    output logic             tx_o,
    output logic             rx_irq
);
    reg_sel_e          sel;
    logic [DIV_W-1:0]  div_q;
    logic              pkt_mode_q, ovf_q;
    status_t           stat;
    logic [REG_W-1:0]  rd_mux;

    logic              tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic [BYTE_W-1:0] tx_dout;
    logic [TXC_W-1:0]  tx_count;

    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [BYTE_W-1:0] rx_byte, rx_dout;
    logic [RXC_W-1:0]  rx_count;

    logic              wr_stat, ovf_set;
    logic              unused_wr_bits;

    assign sel     = reg_sel_e'(addr);
    assign wr_stat = wr_en && (sel == REG_STAT);
    assign tx_push = wr_en && (sel == REG_DATA);
    assign rx_pop  = rd_en && (sel == REG_DATA);
    assign ovf_set = rx_push && rx_full;
    assign unused_wr_bits = ^{wr_data[REG_W-1:DIV_W], wr_data[4], wr_data[1:0]};

    sp_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .push(tx_push), .din(wr_data[BYTE_W-1:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    sp_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst(rst), .div(div_q), .fifo_empty(tx_empty),
        .fifo_data(tx_dout), .fifo_pop(tx_pop), .busy(tx_busy), .tx_o(tx_o)
    );

    sp_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst(rst), .div(div_q), .rx_i(rx_i),
        .push(rx_push), .data(rx_byte)
    );

    sp_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    always_comb begin
        stat.tx_ready  = !tx_full;
        stat.pkt_mode  = pkt_mode_q;
        stat.overflow  = ovf_q;
        stat.pkt_ready = rx_full;
        stat.rx_ready  = !rx_empty;
    end

    assign rx_irq = pkt_mode_q ? stat.pkt_ready : stat.rx_ready;

    always_comb begin
        unique case (sel)
            REG_DATA: rd_mux = rx_empty ? '0 : {{(REG_W-BYTE_W){1'b0}}, rx_dout};
            REG_STAT: rd_mux = pack_status(stat);
            REG_BAUD: rd_mux = {{(REG_W-DIV_W){1'b0}}, div_q};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= DIV_RESET;
            pkt_mode_q <= 1'b0;
            ovf_q      <= 1'b0;
            rd_data    <= '0;
        end else begin
            if (wr_en && (sel == REG_BAUD))
                div_q <= wr_data[DIV_W-1:0];
            if (wr_stat)
                pkt_mode_q <= wr_data[3];
            if (ovf_set)
                ovf_q <= 1'b1;
            else if (wr_stat && wr_data[2])
                ovf_q <= 1'b0;
            if (rd_en)
                rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk #(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 8,
    localparam int TXC_W = $clog2(TX_DEPTH + 1),
    localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       addr,
    input logic             wr_en,
    input logic             clr_bit,
    input logic             tx_o,
    input logic             tx_busy,
    input logic [TXC_W-1:0] tx_count,
    input logic             rx_irq,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             rx_full,
    input logic [RXC_W-1:0] rx_count,
    input logic             ovf
);
    // R8
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_count != '0));

    // R7
    rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rx_count <= RXC_W'(RX_DEPTH));

    // R4
    tx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tx_count <= TXC_W'(TX_DEPTH));

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_o);

    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(rx_push && rx_full));

    // R9
    drop_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full && !rx_pop) |=> (rx_count == $past(rx_count)));

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && clr_bit && !(rx_push && rx_full)) |=> !ovf);
endmodule

bind serial_port_ctrl serial_port_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .clr_bit(wr_data[2]),
    .tx_o(tx_o), .tx_busy(tx_busy), .tx_count(tx_count), .rx_irq(rx_irq),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
    .rx_count(rx_count), .ovf(ovf_q)
);

// File: tb/tb_serial_port_ctrl.sv
module tb_serial_port_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rx_i = 1'b1;
    logic        tx_o;
    logic        rx_irq;

    int checks = 0;
    int errors = 0;
    int cur_div = 23;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_port_ctrl dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_i(rx_i), .tx_o(tx_o), .rx_irq(rx_irq)
    );

    function automatic logic [15:0] st(bit txr, bit pm, bit ov, bit pr, bit rr);
        return {11'd0, txr, pm, ov, pr, rr};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic send_rx(logic [7:0] b);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            rx_i = fr[i];
            repeat (cur_div + 1) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic capture_tx(output logic [7:0] b, output bit ok);
        int guard;
        guard = 0;
        ok = 1'b1;
        b = '0;
        while (tx_o === 1'b1 && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 60000) begin
            ok = 1'b0;
            return;
        end
        repeat ((cur_div + 1) / 2) @(negedge clk);
        if (tx_o !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (cur_div + 1) @(negedge clk);
            b[i] = tx_o;
        end
        repeat (cur_div + 1) @(negedge clk);
        if (tx_o !== 1'b1) ok = 1'b0;
    endtask

    task automatic tx_burst(logic [39:0] bytes);
        @(negedge clk);
        addr = 2'd0; wr_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wr_data = {8'd0, bytes[i*8 +: 8]};
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [7:0]  got;
        logic [7:0]  pkt [9];
        logic [39:0] burst;
        bit          ok;
        int          lows;

        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 tx idle", tx_o, 1);
        chk("R1 irq", rx_irq, 0);
        reg_read(2'd1, r); chk("R1 status", r, st(1,0,0,0,0));
        reg_read(2'd2, r); chk("R1 divisor", r, 16'h0017);

        // R10 / R2: reserved bits and divisor field width
        reg_write(2'd2, 16'hFFFF);
        reg_read(2'd2, r); chk("R10 divisor reserved", r, 16'h1FFF);
        reg_write(2'd2, 16'd23);
        reg_read(2'd2, r); chk("R2 divisor rw", r, 16'd23);
        reg_write(2'd1, 16'hFFE3);
        reg_read(2'd1, r); chk("R10 status reserved", r, st(1,0,0,0,0));
        reg_write(2'd1, 16'h0008);
        reg_read(2'd1, r); chk("R8 mode bit rw", r, st(1,1,0,0,0));
        reg_write(2'd1, 16'h0000);
        reg_read(3'd3, r); chk("R10 unused address", r, 0);

        // R3 / R4: transmit burst that fills the FIFO, extra write dropped
        burst = {8'h3C, 8'hFF, 8'h80, 8'h01, 8'hA5};
        fork
            begin
                tx_burst(burst);
                reg_read(2'd1, r);
                chk("R4 tx full status", r, st(0,0,0,0,0));
                reg_write(2'd0, 16'h00EE);
            end
            begin
                for (int i = 0; i < 5; i++) begin
                    capture_tx(got, ok);
                    chk("R3 tx frame", ok, 1);
                    chk("R3 tx byte order", got, burst[i*8 +: 8]);
                end
            end
        join
        lows = 0;
        repeat (3 * (cur_div + 1)) begin
            @(negedge clk);
            if (tx_o !== 1'b1) lows++;
        end
        chk("R4 dropped write not sent", lows, 0);
        reg_read(2'd1, r); chk("R4 tx ready again", r, st(1,0,0,0,0));

        // R5 / R6: single byte receive
        send_rx(8'h5A);
        reg_read(2'd1, r); chk("R6 rx ready", r, st(1,0,0,0,1));
        chk("R8 irq mode 0", rx_irq, 1);
        reg_read(2'd0, r); chk("R5 rx byte", r, 16'h005A);
        reg_read(2'd1, r); chk("R6 rx drained", r, st(1,0,0,0,0));
        chk("R8 irq clear", rx_irq, 0);
        reg_read(2'd0, r); chk("R6 empty read", r, 0);

        // R5: short low pulse rejected as a start bit
        @(negedge clk); rx_i = 1'b0;
        repeat (5) @(negedge clk); rx_i = 1'b1;
        repeat (3 * (cur_div + 1)) @(negedge clk);
        reg_read(2'd1, r); chk("R5 glitch rejected", r, st(1,0,0,0,0));

        // R7 / R8 / R9: packet, mode and overflow
        for (int i = 0; i < 9; i++) pkt[i] = 8'($urandom_range(0, 255));
        for (int i = 0; i < 7; i++) send_rx(pkt[i]);
        reg_read(2'd1, r); chk("R7 seven bytes", r, st(1,0,0,0,1));
        reg_write(2'd1, 16'h0008);
        @(negedge clk);
        chk("R8 irq mode 1 partial", rx_irq, 0);
        send_rx(pkt[7]);
        reg_read(2'd1, r); chk("R7 eight bytes", r, st(1,1,0,1,1));
        chk("R8 irq mode 1 full", rx_irq, 1);
        send_rx(pkt[8] ^ 8'h55);
        reg_read(2'd1, r); chk("R9 overflow set", r, st(1,1,1,1,1));
        reg_write(2'd1, 16'h0008);
        reg_read(2'd1, r); chk("R9 write 0 keeps", r, st(1,1,1,1,1));
        reg_write(2'd1, 16'h000C);
        reg_read(2'd1, r); chk("R9 write 1 clears", r, st(1,1,0,1,1));
        for (int i = 0; i < 8; i++) begin
            reg_read(2'd0, r);
            chk("R9 contents kept", r, {8'd0, pkt[i]});
        end
        reg_read(2'd1, r); chk("R7 drained", r, st(1,1,0,0,0));
        chk("R8 irq mode 1 empty", rx_irq, 0);
        reg_write(2'd1, 16'h0000);

        // R2 / R3 / R5: random divisors and bytes
        for (int it = 0; it < 6; it++) begin
            cur_div = int'($urandom_range(23, 60));
            reg_write(2'd2, 16'(cur_div));
            reg_read(2'd2, r); chk("R2 random divisor", r, 16'(cur_div));
            for (int k = 0; k < 2; k++) begin
                pkt[0] = 8'($urandom_range(0, 255));
                fork
                    reg_write(2'd0, {8'd0, pkt[0]});
                    capture_tx(got, ok);
                join
                chk("R2 tx timing", ok, 1);
                chk("R3 random tx", got, pkt[0]);
                pkt[1] = 8'($urandom_range(0, 255));
                send_rx(pkt[1]);
                reg_read(2'd0, r); chk("R5 random rx", r, {8'd0, pkt[1]});
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule